// File: doc/BRIEF.md
# Video Parameter Staging Controller

This block sits in the fabric next to a serial camera-style video transmitter and decides the cycle in which each requested video setting reaches the transmitter's control inputs. Software or upstream logic posts new values for the line width, the virtual channel, the data type, the lane count and the frame format. The block holds each value in a shadow register and moves it to its output only while that setting's update window is open. It also forwards the frame and line sync levels, the valid flag and the 64-bit pixel word, each with one register stage. The transmitter therefore always sees a sync edge that fits the settings it carries.

Line width and virtual channel may move only while the forwarded frame sync is low. The data type may move only while the forwarded line sync is low. If a sync would rise in the same cycle that one of its settings changes, the rise is held back by one cycle, so every setting is steady for at least one clock before the edge that latches it. Lane count and frame format may move only while the transmitter is held in reset. A request for either one pulls both active-low resets low. The new value is applied while reset is held, and both resets are released together. A separate request pulses only the controller reset, which is the reset needed after a change of line width.

Top module: `vid_param_stager`

## Requirements
- R1: While `rst_n` is low, `phy_rst_n_o` and `ctl_rst_n_o` are low. The line width reads HRES_INIT (default 1920), the virtual channel reads 0, the data type reads DT_INIT (default 0x2A), the lane code reads 2'b11, the frame format reads 0, and all forwarded signals read 0. Both resets go high together on the RST_HOLD-th rising clock edge after `rst_n` goes high.
- R2: `valid_o` and `data_o` equal `valid_in` and `data_in` one clock later.
- R3: A line-width/channel request (`vid_wr`) is captured at a clock edge. It reaches `hres_o`/`vc_o` at the first later edge where the forwarded `vsync_o` is low before that edge. A later request overwrites one that has not yet been applied.
- R4: A data-type request (`dt_wr`) follows the same rule as R3, with `hsync_o` as the window.
- R5: `vsync_o` follows `vsync_in` one clock later, and falling edges are never delayed. A rise that would coincide with an update of `hres_o`/`vc_o` is deferred by one clock. A deferred rise still occurs even if `vsync_in` has already fallen.
- R6: `hsync_o` behaves as in R5, with the deferral tied to updates of `dt_o`.
- R7: A lane request with code 2'b00 (lane 0), 2'b01 (lanes 0-1) or 2'b11 (all four), or any frame-format request (`fmode_req` 0 = general, 1 = accurate), has these effects. Both resets go low at the next edge. The new value appears one edge later. Both resets rise together RST_HOLD edges after the last such request.
- R8: A lane request with code 2'b10 is rejected. `lane_err_o` is high for exactly one clock, `lanes_o` keeps its value, and no reset is issued.
- R9: `ctl_rst_req` drives `ctl_rst_n_o` low for RST_HOLD clocks while `phy_rst_n_o` stays high. A lane or format request during that time also pulls `phy_rst_n_o` low, and the two resets release together.
- R10: `phy_rst_n_o` is never low while `ctl_rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| vsync_in | input | 1 | Frame sync from the video source |
| hsync_in | input | 1 | Line sync from the video source |
| valid_in | input | 1 | Pixel word qualifier |
| data_in | input | 64 | Pixel word |
| vid_wr | input | 1 | Strobe for a line-width/channel request |
| hres_req | input | 16 | Requested line width |
| vc_req | input | 2 | Requested virtual channel |
| dt_wr | input | 1 | Strobe for a data-type request |
| dt_req | input | 6 | Requested data type |
| lanes_wr | input | 1 | Strobe for a lane-count request |
| lanes_req | input | 2 | Requested lane code |
| fmode_wr | input | 1 | Strobe for a frame-format request |
| fmode_req | input | 1 | Requested frame format |
| ctl_rst_req | input | 1 | Request for a controller-only reset pulse |
| vsync_o | output | 1 | Forwarded frame sync |
| hsync_o | output | 1 | Forwarded line sync |
| valid_o | output | 1 | Forwarded qualifier |
| data_o | output | 64 | Forwarded pixel word |
| hres_o | output | 16 | Applied line width |
| vc_o | output | 2 | Applied virtual channel |
| dt_o | output | 6 | Applied data type |
| lanes_o | output | 2 | Applied lane code |
| fmode_o | output | 1 | Applied frame format |
| phy_rst_n_o | output | 1 | Active-low PHY reset |
| ctl_rst_n_o | output | 1 | Active-low controller reset |
| lane_err_o | output | 1 | One-cycle flag for a rejected lane code |

## Verification
The bench drives requests that land while a sync is high, at the very edge where it falls, and back to back, so that a pending value must be overwritten. A design that applied early would change a setting under a high sync. A design that forgot to defer would raise the sync in the same cycle the setting changes. A design that dropped the deferral flag would swallow single-cycle sync pulses, which a dedicated phase with one-cycle pulses exposes. On the reset side, the bench mixes illegal lane codes, controller-only pulses that are escalated by a lane request, and requests repeated during a hold. These catch a value that changes outside reset, resets that release in different cycles, and a hold counter that does not restart.

// File: rtl/vps_pkg.sv
// Package: shared lane-code and frame-format encodings for the staging controller.
// Assumes: lane codes are the 2-bit values decoded by the downstream transmitter.
package vps_pkg;
    typedef enum logic [1:0] {
        LANE_ONE  = 2'b00,
        LANE_TWO  = 2'b01,
        LANE_BAD  = 2'b10,
        LANE_FOUR = 2'b11
    } lane_code_t;

    typedef enum logic {
        FMT_GENERAL  = 1'b0,
        FMT_ACCURATE = 1'b1
    } frame_fmt_t;

    // Returns 1 when a lane code may be forwarded.
    function automatic logic lane_code_ok(input logic [1:0] code);
        return code != LANE_BAD;
    endfunction
endpackage

// File: rtl/vps_window_stage.sv
// Module: shadow register for a setting whose update window is "sync low".
// A request is captured into a pending slot and moved to the output at the
// first edge where the forwarded sync is low before that edge. upd_o tells the
// sync gate that the output changes at this edge.
// Assumes: sync_i is the forwarded (registered) sync level of the same clock.
module vps_window_stage #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] req_i,
    input  logic         sync_i,
    output logic [W-1:0] val_o,
    output logic         upd_o
);
    logic [W-1:0] pend_q;
    logic         pend_v_q;

    // Window open and something waiting: the output moves at this edge.
    assign upd_o = pend_v_q & ~sync_i;

    // Pending slot capture and application to the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_o    <= INIT;
            pend_q   <= INIT;
            pend_v_q <= 1'b0;
        end else begin
            if (upd_o) val_o <= pend_q;
            if (wr_i) begin
                pend_q   <= req_i;
                pend_v_q <= 1'b1;
            end else if (upd_o) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    // R3 R4: the value moves only while the forwarded sync is low on both sides of the edge
    // R3
    win_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(val_o) |-> (!sync_i && !$past(sync_i)));
endmodule

// File: rtl/vps_sync_gate.sv
// Module: forwards one sync level through a register and defers its rising
// edge by one clock when the settings it guards change at that same edge.
// Falling edges pass straight through.
// Assumes: hold_i is the update strobe of the matching window stage.
module vps_sync_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic hold_i,
    output logic sync_o
);
    logic defer_q;
    logic want_rise;

    // A rise is due when the output is low and either the input or a deferral asks for it.
    assign want_rise = ~sync_o & (sync_i | defer_q);

    // Sync register with one-cycle deferral of rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_o  <= 1'b0;
            defer_q <= 1'b0;
        end else if (want_rise && hold_i) begin
            sync_o  <= 1'b0;
            defer_q <= 1'b1;
        end else if (want_rise) begin
            sync_o  <= 1'b1;
            defer_q <= 1'b0;
        end else begin
            sync_o  <= sync_i;
            defer_q <= 1'b0;
        end
    end

    // R5
    defer_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_q && !hold_i) |=> sync_o);
    // R6
    no_rise_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> !$past(hold_i));
endmodule

// File: rtl/vps_reset_seq.sv
// Module: drives the paired active-low resets. A configuration event pulls
// both low; a controller event pulls only the controller reset low. Any
// event reloads the hold counter; both release in the same cycle.
// Assumes: HOLD >= 2 so the configuration value lands while reset is held.
module vps_reset_seq #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ev_i,
    input  logic ctl_ev_i,
    output logic phy_rst_n_o,
    output logic ctl_rst_n_o,
    output logic apply_o
);
    localparam int HOLD_EFF = (HOLD < 2) ? 2 : HOLD;
    localparam int CNT_W    = $clog2(HOLD_EFF);

    logic             phy_low_q;
    logic             ctl_low_q;
    logic [CNT_W-1:0] cnt_q;

    assign phy_rst_n_o = ~phy_low_q;
    assign ctl_rst_n_o = ~ctl_low_q;

    // Reset hold state machine with reloadable counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_low_q <= 1'b1;
            ctl_low_q <= 1'b1;
            cnt_q     <= CNT_W'(HOLD_EFF - 1);
            apply_o   <= 1'b0;
        end else begin
            apply_o <= cfg_ev_i;
            if (cfg_ev_i) begin
                phy_low_q <= 1'b1;
                ctl_low_q <= 1'b1;
                cnt_q     <= CNT_W'(HOLD_EFF - 1);
            end else if (ctl_ev_i) begin
                ctl_low_q <= 1'b1;
                cnt_q     <= CNT_W'(HOLD_EFF - 1);
            end else if (ctl_low_q) begin
                if (cnt_q == '0) begin
                    phy_low_q <= 1'b0;
                    ctl_low_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R10
    phy_implies_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_rst_n_o |-> !ctl_rst_n_o);
    // R7
    joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_n_o) |-> $rose(ctl_rst_n_o));
endmodule

// File: rtl/vps_cfg_stage.sv
// Module: shadow registers for lane count and frame format. Legal requests
// raise cfg_ev_o; the pending values move to the outputs on apply_i, which
// the reset sequencer raises one edge later while reset is held. An illegal
// lane code is dropped and flagged for one cycle.
// Assumes: apply_i comes from vps_reset_seq.
module vps_cfg_stage
    import vps_pkg::*;
#(
    parameter logic [1:0] LANES_INIT = LANE_FOUR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lanes_wr_i,
    input  logic [1:0] lanes_req_i,
    input  logic       fmode_wr_i,
    input  logic       fmode_req_i,
    input  logic       apply_i,
    output logic       cfg_ev_o,
    output logic [1:0] lanes_o,
    output logic       fmode_o,
    output logic       err_o
);
    logic [1:0] lanes_pend_q;
    logic       fmode_pend_q;
    logic       lanes_ok;

    assign lanes_ok = lanes_wr_i & lane_code_ok(lanes_req_i);
    assign cfg_ev_o = lanes_ok | fmode_wr_i;

    // Pending capture, application under reset, and rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_o      <= LANES_INIT;
            lanes_pend_q <= LANES_INIT;
            fmode_o      <= FMT_GENERAL;
            fmode_pend_q <= FMT_GENERAL;
            err_o        <= 1'b0;
        end else begin
            err_o <= lanes_wr_i & ~lane_code_ok(lanes_req_i);
            if (apply_i) begin
                lanes_o <= lanes_pend_q;
                fmode_o <= fmode_pend_q;
            end
            if (lanes_ok)   lanes_pend_q <= lanes_req_i;
            if (fmode_wr_i) fmode_pend_q <= fmode_req_i;
        end
    end

    // R8
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lanes_o != LANE_BAD);
endmodule

// File: rtl/vid_param_stager.sv
// Module: top of the video parameter staging controller. Forwards syncs,
// valid and pixel data with one register stage and applies each requested
// setting only inside its legal window.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module vid_param_stager
    import vps_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                HRES_W    = 16,
    parameter int                VC_W      = 2,
    parameter int                DT_W      = 6,
    parameter int                RST_HOLD  = 4,
    parameter logic [HRES_W-1:0] HRES_INIT = 16'd1920,
    parameter logic [DT_W-1:0]   DT_INIT   = 6'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              hsync_in,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              vid_wr,
    input  logic [HRES_W-1:0] hres_req,
    input  logic [VC_W-1:0]   vc_req,
    input  logic              dt_wr,
    input  logic [DT_W-1:0]   dt_req,
    input  logic              lanes_wr,
    input  logic [1:0]        lanes_req,
    input  logic              fmode_wr,
    input  logic              fmode_req,
    input  logic              ctl_rst_req,
    output logic              vsync_o,
    output logic              hsync_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [HRES_W-1:0] hres_o,
    output logic [VC_W-1:0]   vc_o,
    output logic [DT_W-1:0]   dt_o,
    output logic [1:0]        lanes_o,
    output logic              fmode_o,
    output logic              phy_rst_n_o,
    output logic              ctl_rst_n_o,
    output logic              lane_err_o
);
    localparam int                     FW_W     = HRES_W + VC_W;
    localparam logic [FW_W-1:0]        FW_INIT  = {HRES_INIT, {VC_W{1'b0}}};

    logic [FW_W-1:0] frame_val;
    logic            frame_upd;
    logic            line_upd;
    logic            cfg_ev;
    logic            cfg_apply;

    // Frame-window settings: line width and virtual channel share one window.
    vps_window_stage #(.W(FW_W), .INIT(FW_INIT)) u_frame_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (vid_wr),
        .req_i ({hres_req, vc_req}),
        .sync_i(vsync_o),
        .val_o (frame_val),
        .upd_o (frame_upd)
    );
    assign hres_o = frame_val[FW_W-1:VC_W];
    assign vc_o   = frame_val[VC_W-1:0];

    // Line-window setting: data type.
    vps_window_stage #(.W(DT_W), .INIT(DT_INIT)) u_line_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (dt_wr),
        .req_i (dt_req),
        .sync_i(hsync_o),
        .val_o (dt_o),
        .upd_o (line_upd)
    );

    vps_sync_gate u_vsync_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(vsync_in),
        .hold_i(frame_upd),
        .sync_o(vsync_o)
    );

    vps_sync_gate u_hsync_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(hsync_in),
        .hold_i(line_upd),
        .sync_o(hsync_o)
    );

    vps_cfg_stage #(.LANES_INIT(LANE_FOUR)) u_cfg_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .lanes_wr_i (lanes_wr),
        .lanes_req_i(lanes_req),
        .fmode_wr_i (fmode_wr),
        .fmode_req_i(fmode_req),
        .apply_i    (cfg_apply),
        .cfg_ev_o   (cfg_ev),
        .lanes_o    (lanes_o),
        .fmode_o    (fmode_o),
        .err_o      (lane_err_o)
    );

    vps_reset_seq #(.HOLD(RST_HOLD)) u_reset_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ev_i   (cfg_ev),
        .ctl_ev_i   (ctl_rst_req),
        .phy_rst_n_o(phy_rst_n_o),
        .ctl_rst_n_o(ctl_rst_n_o),
        .apply_o    (cfg_apply)
    );

    // Pixel path: one register stage for qualifier and word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_in;
            data_o  <= data_in;
        end
    end

    // R7
    lanes_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lanes_o) || !$stable(fmode_o)) |->
            (!phy_rst_n_o && !ctl_rst_n_o && !$past(phy_rst_n_o)));
    // R2
    pixel_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(valid_in)));
endmodule

// File: tb/vid_param_stager_bench.sv
// Bench: behavioural reference model updated every clock and compared a
// quarter period after each rising edge; inputs change on falling edges.
module vid_param_stager_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RST_HOLD   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync_in = 0, hsync_in = 0, valid_in = 0;
    logic [63:0] data_in = '0;
    logic        vid_wr = 0, dt_wr = 0, lanes_wr = 0, fmode_wr = 0, fmode_req = 0, ctl_rst_req = 0;
    logic [15:0] hres_req = '0;
    logic [1:0]  vc_req = '0, lanes_req = '0;
    logic [5:0]  dt_req = '0;
    logic        vsync_o, hsync_o, valid_o, fmode_o, phy_rst_n_o, ctl_rst_n_o, lane_err_o;
    logic [63:0] data_o;
    logic [15:0] hres_o;
    logic [1:0]  vc_o, lanes_o;
    logic [5:0]  dt_o;

    int checks = 0;
    int failures = 0;
    int sync_mode = 0;
    int tcount = 0;
    int defer_v_seen = 0, defer_h_seen = 0, err_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_param_stager #(.RST_HOLD(RST_HOLD)) u_vid_param_stager (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
        .valid_in(valid_in), .data_in(data_in), .vid_wr(vid_wr), .hres_req(hres_req),
        .vc_req(vc_req), .dt_wr(dt_wr), .dt_req(dt_req), .lanes_wr(lanes_wr),
        .lanes_req(lanes_req), .fmode_wr(fmode_wr), .fmode_req(fmode_req),
        .ctl_rst_req(ctl_rst_req), .vsync_o(vsync_o), .hsync_o(hsync_o),
        .valid_o(valid_o), .data_o(data_o), .hres_o(hres_o), .vc_o(vc_o), .dt_o(dt_o),
        .lanes_o(lanes_o), .fmode_o(fmode_o), .phy_rst_n_o(phy_rst_n_o),
        .ctl_rst_n_o(ctl_rst_n_o), .lane_err_o(lane_err_o));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Reference model state
    int   m_hres, m_vc, m_dt, m_hres_p, m_vc_p, m_dt_p, m_lanes, m_lanes_p;
    bit   m_fv, m_dv, m_vs, m_hs, m_vdef, m_hdef, m_fmode, m_fmode_p, m_apply;
    bit   m_phy_low, m_ctl_low, m_err, m_valid;
    int   m_cnt;
    logic [63:0] m_data;

    always @(posedge clk) begin
        bit vupd, hupd, want, cfg;
        if (!rst_n) begin
            m_hres = 1920; m_vc = 0; m_dt = 'h2A; m_hres_p = 1920; m_vc_p = 0; m_dt_p = 'h2A;
            m_fv = 0; m_dv = 0; m_vs = 0; m_hs = 0; m_vdef = 0; m_hdef = 0;
            m_lanes = 3; m_lanes_p = 3; m_fmode = 0; m_fmode_p = 0; m_apply = 0;
            m_phy_low = 1; m_ctl_low = 1; m_cnt = RST_HOLD - 1; m_err = 0;
            m_valid = 0; m_data = '0;
        end else begin
            vupd = m_fv && !m_vs;
            hupd = m_dv && !m_hs;
            want = !m_vs && (vsync_in || m_vdef);
            if (want && vupd) begin m_vdef = 1; defer_v_seen++; end
            else if (want) begin m_vs = 1; m_vdef = 0; end
            else begin m_vs = vsync_in; m_vdef = 0; end
            want = !m_hs && (hsync_in || m_hdef);
            if (want && hupd) begin m_hdef = 1; defer_h_seen++; end
            else if (want) begin m_hs = 1; m_hdef = 0; end
            else begin m_hs = hsync_in; m_hdef = 0; end
            if (vupd) begin m_hres = m_hres_p; m_vc = m_vc_p; end
            if (vid_wr) begin m_hres_p = hres_req; m_vc_p = vc_req; m_fv = 1; end
            else if (vupd) m_fv = 0;
            if (hupd) m_dt = m_dt_p;
            if (dt_wr) begin m_dt_p = dt_req; m_dv = 1; end
            else if (hupd) m_dv = 0;
            if (m_apply) begin m_lanes = m_lanes_p; m_fmode = m_fmode_p; end
            cfg = (lanes_wr && lanes_req != 2'b10) || fmode_wr;
            m_err = lanes_wr && lanes_req == 2'b10;
            if (m_err) err_seen++;
            if (lanes_wr && lanes_req != 2'b10) m_lanes_p = lanes_req;
            if (fmode_wr) m_fmode_p = fmode_req;
            m_apply = cfg;
            if (cfg) begin m_phy_low = 1; m_ctl_low = 1; m_cnt = RST_HOLD - 1; end
            else if (ctl_rst_req) begin m_ctl_low = 1; m_cnt = RST_HOLD - 1; end
            else if (m_ctl_low) begin
                if (m_cnt == 0) begin m_phy_low = 0; m_ctl_low = 0; end
                else m_cnt--;
            end
            m_valid = valid_in; m_data = data_in;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            chk("R2 valid", valid_o, m_valid);
            chk("R2 data", data_o, m_data);
            chk("R3 hres", hres_o, m_hres);
            chk("R3 vc", vc_o, m_vc);
            chk("R4 dtype", dt_o, m_dt);
            chk("R5 vsync", vsync_o, m_vs);
            chk("R6 hsync", hsync_o, m_hs);
            chk("R7 lanes", lanes_o, m_lanes);
            chk("R7 fmode", fmode_o, m_fmode);
            chk("R8 lane_err", lane_err_o, m_err);
            chk("R9 ctl_rst_n", ctl_rst_n_o, !m_ctl_low);
            chk("R10 phy_rst_n", phy_rst_n_o, !m_phy_low);
        end
    end

    // Sync and pixel generator
    always @(negedge clk) begin
        tcount++;
        if (sync_mode == 0) begin
            hsync_in <= (tcount % 12) >= 2 && (tcount % 12) <= 7;
            vsync_in <= ((tcount / 12) % 6) >= 1 && ((tcount / 12) % 6) <= 4;
        end else begin
            hsync_in <= (tcount % 5) == 0;
            vsync_in <= (tcount % 7) == 0;
        end
        valid_in <= $urandom_range(0, 3) != 0;
        data_in  <= {$urandom, $urandom};
    end

    task automatic idle_reqs();
        vid_wr = 0; dt_wr = 0; lanes_wr = 0; fmode_wr = 0; ctl_rst_req = 0;
    endtask

    task automatic random_video(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vid_wr = $urandom_range(0, 4) == 0;
            hres_req = 16'($urandom); vc_req = 2'($urandom);
            dt_wr = $urandom_range(0, 3) == 0;
            dt_req = 6'($urandom);
        end
        @(negedge clk); idle_reqs();
    endtask

    task automatic pulse_cfg(input bit is_lane, input logic [1:0] code, input int gap);
        @(negedge clk);
        if (is_lane) begin lanes_wr = 1; lanes_req = code; end
        else begin fmode_wr = 1; fmode_req = code[0]; end
        @(negedge clk); idle_reqs();
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 phy low", phy_rst_n_o, 1'b0);
        chk("R1 ctl low", ctl_rst_n_o, 1'b0);
        chk("R1 lanes", lanes_o, 2'b11);
        chk("R1 hres", hres_o, 16'd1920);
        chk("R1 dtype", dt_o, 6'h2A);
        chk("R1 vsync", vsync_o, 1'b0);
        rst_n = 1;
        repeat (RST_HOLD - 1) @(posedge clk);
        #1 chk("R1 still held", phy_rst_n_o, 1'b0);
        @(posedge clk);
        #1 chk("R1 joint release", {phy_rst_n_o, ctl_rst_n_o}, 2'b11);
        random_video(400);
        sync_mode = 1;
        random_video(300);
        sync_mode = 0;
        // R7 legal lane/format updates, R8 illegal code
        pulse_cfg(1, 2'b01, 10);
        pulse_cfg(1, 2'b10, 6);
        pulse_cfg(0, 2'b01, 10);
        pulse_cfg(1, 2'b00, 1);
        pulse_cfg(1, 2'b11, 10);
        // R9 controller-only pulse, then escalation
        @(negedge clk); ctl_rst_req = 1; @(negedge clk); idle_reqs();
        repeat (8) @(negedge clk);
        @(negedge clk); ctl_rst_req = 1; @(negedge clk); idle_reqs();
        pulse_cfg(1, 2'b01, 10);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            vid_wr = $urandom_range(0, 5) == 0; hres_req = 16'($urandom); vc_req = 2'($urandom);
            dt_wr = $urandom_range(0, 4) == 0; dt_req = 6'($urandom);
            lanes_wr = $urandom_range(0, 15) == 0; lanes_req = 2'($urandom);
            fmode_wr = $urandom_range(0, 20) == 0; fmode_req = 1'($urandom);
            ctl_rst_req = $urandom_range(0, 25) == 0;
        end
        @(negedge clk); idle_reqs();
        repeat (20) @(negedge clk);
        done = 1;
        chk("R5 deferral exercised", 64'(defer_v_seen > 0), 64'd1);
        chk("R6 deferral exercised", 64'(defer_h_seen > 0), 64'd1);
        chk("R8 rejection exercised", 64'(err_seen > 0), 64'd1);
        finish_run();
    end
endmodule